// File: doc/BRIEF.md
# Sub-cycle Dithered PWM Generator

This block drives one pulse-width-modulated output from an 8-bit duty word, stepping once per system clock. A full PWM period is 256 clocks long, but it is cut into equal modulation sub-cycles so that the output toggles several times per period. That pushes the ripple seen by a slow load to a higher frequency while the long-term average still resolves all 256 duty steps.

The duty word is split into a coarse part and a small remainder. The coarse part sets the high time of every sub-cycle. The remainder grants one extra high clock to each of the lowest-numbered sub-cycles. Two splits are offered: four sub-cycles of 64 clocks, or two sub-cycles of 128 clocks.

Software writes the duty word through a strobe and drives a mode select and an enable. The split, the sequencing and the double-buffering are handled inside the block. New duty and mode values are adopted only at a full-period boundary, so no sub-cycle is ever built from two different settings.

Top module: `dpwm_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pwm_out` is 0. Reset clears the stored duty to 0 and the mode to four sub-cycles.
- R2: While `pwm_en` is 1, the position counter advances by one per clock and wraps after 256 clocks. `pwm_out` is registered: after the n-th rising edge counted from the enabling edge (n = 0, 1, ...), it shows position n mod 256.
- R3: With `mode_sel` = 0, the period is four 64-clock sub-cycles. The coarse value is duty[7:2] and the remainder is duty[1:0]. Sub-cycle i (i = 0..3) is high for coarse+1 clocks when i < remainder, and for coarse clocks otherwise. For example, duty 100, 101, 102 and 103 give high times of 25/25/25/25, 26/25/25/25, 26/26/25/25 and 26/26/26/25.
- R4: With `mode_sel` = 1, the period is two 128-clock sub-cycles. The coarse value is duty[7:1] and the remainder is duty[0]. Sub-cycle 0 is high for coarse+1 clocks when duty[0] is 1; sub-cycle 1 is high for coarse clocks.
- R5: Within each sub-cycle the output is high from the sub-cycle's first clock for its whole high time, then low for the rest of the sub-cycle.
- R6: A value on `duty_in` with `duty_we` = 1 is stored. It governs the output from the start of the next full period, including when the write falls on the last clock of a period. The period in progress keeps its old duty.
- R7: `mode_sel` is sampled only at a full-period boundary, or while disabled. A change in mid-period takes effect at the next period.
- R8: When `pwm_en` is 0, `pwm_out` is 0 from the next rising edge and the position counter is held at 0. Re-enabling therefore starts at sub-cycle 0.
- R9: A duty of 0 keeps `pwm_out` low for the whole period in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the PWM step clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_in | input | 8 | Duty word to store |
| duty_we | input | 1 | Write strobe for `duty_in` |
| mode_sel | input | 1 | 0: four 64-clock sub-cycles, 1: two 128-clock sub-cycles |
| pwm_en | input | 1 | 1 runs the generator, 0 forces the output low and the counter to 0 |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The output carries one register stage. The level for counter position n therefore appears after the n-th rising edge, counted from the edge that first sees `pwm_en` high, and the bench reads it on the following falling edge. The capture task records 256 consecutive falling-edge samples per period and checks high counts per 64-clock quarter, plus contiguity within each sub-cycle.

Duty writes and mode changes are placed at a known sample index, so the edge that registers them is known exactly. A write on the last clock of a period must show in the very next captured period. Disabling is checked at the first falling edge after the edge that sees `pwm_en` low.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int CNT_W     = 8;
  localparam int QUAD_LOG2 = 2;
  localparam int DUAL_LOG2 = 1;

  typedef enum logic {
    SPLIT_QUAD = 1'b0,
    SPLIT_DUAL = 1'b1
  } split_e;
endpackage

// File: rtl/dpwm_cycle_counter.sv
module dpwm_cycle_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] pos,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || !en) pos <= '0;
    else            pos <= pos + 1'b1;
  end

  assign wrap = en && (pos == LAST);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> pos == CNT_W'($past(pos) + 1'b1));

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> pos == '0);
endmodule

// File: rtl/dpwm_duty_latch.sv
module dpwm_duty_latch
  import dpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wrap,
  input  logic [CNT_W-1:0] duty_in,
  input  logic             duty_we,
  input  split_e           mode_in,
  output logic [CNT_W-1:0] act_duty,
  output split_e           act_mode
);
  logic [CNT_W-1:0] shadow;
  logic [CNT_W-1:0] shadow_nxt;
  logic             load;

  assign shadow_nxt = duty_we ? duty_in : shadow;
  assign load       = !en || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow   <= '0;
      act_duty <= '0;
      act_mode <= SPLIT_QUAD;
    end else begin
      shadow <= shadow_nxt;
      if (load) begin
        act_duty <= shadow_nxt;
        act_mode <= mode_in;
      end
    end
  end
endmodule

// File: rtl/dpwm_sub_compare.sv
module dpwm_sub_compare #(
  parameter int CNT_W    = 8,
  parameter int SUB_LOG2 = 2
) (
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] duty,
  output logic             high
);
  localparam int PW      = CNT_W + 1;
  localparam int SLOT_W  = CNT_W - SUB_LOG2;
  localparam int SLOT_MK = (1 << SLOT_W) - 1;
  localparam int REM_MK  = (1 << SUB_LOG2) - 1;

  logic [PW-1:0] pos_x, duty_x;
  logic [PW-1:0] sub_idx, slot_pos, coarse, remain, thresh;

  always_comb begin
    pos_x    = {1'b0, pos};
    duty_x   = {1'b0, duty};
    sub_idx  = pos_x >> SLOT_W;
    slot_pos = pos_x & PW'(SLOT_MK);
    coarse   = duty_x >> SUB_LOG2;
    remain   = duty_x & PW'(REM_MK);
    thresh   = coarse + PW'(sub_idx < remain);
    high     = slot_pos < thresh;
  end
endmodule

// File: rtl/dpwm_top.sv
module dpwm_top
  import dpwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] duty_in,
  input  logic       duty_we,
  input  logic       mode_sel,
  input  logic       pwm_en,
  output logic       pwm_out
);
  localparam int NVAR = 2;

  logic [CNT_W-1:0] pos;
  logic             wrap;
  logic [CNT_W-1:0] act_duty;
  split_e           act_mode;
  logic [NVAR-1:0]  high_v;

  dpwm_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (pwm_en),
    .pos  (pos),
    .wrap (wrap)
  );

  dpwm_duty_latch #(.CNT_W(CNT_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .en       (pwm_en),
    .wrap     (wrap),
    .duty_in  (duty_in),
    .duty_we  (duty_we),
    .mode_in  (split_e'(mode_sel)),
    .act_duty (act_duty),
    .act_mode (act_mode)
  );

  for (genvar k = 0; k < NVAR; k++) begin : g_split
    localparam int SL = (k == 0) ? QUAD_LOG2 : DUAL_LOG2;
    dpwm_sub_compare #(.CNT_W(CNT_W), .SUB_LOG2(SL)) u_cmp (
      .pos  (pos),
      .duty (act_duty),
      .high (high_v[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= pwm_en && high_v[act_mode];
  end

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (rst)
    !pwm_en |=> !pwm_out);

  // R9
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (act_duty == '0) |=> !pwm_out);

  // R6
  hold_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (pos != '0) |-> $stable(act_duty));

  // R7
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (pos != '0) |-> $stable(act_mode));
endmodule

// File: tb/tb_dpwm_top.sv
module tb_dpwm_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 15;

  // {mode, duty, q0, q1, q2, q3}: high clocks per 64-clock quarter
  localparam logic [40:0] TBL [NV] = '{
    {1'b0, 8'd100, 8'd25, 8'd25, 8'd25, 8'd25},
    {1'b0, 8'd101, 8'd26, 8'd25, 8'd25, 8'd25},
    {1'b0, 8'd102, 8'd26, 8'd26, 8'd25, 8'd25},
    {1'b0, 8'd103, 8'd26, 8'd26, 8'd26, 8'd25},
    {1'b0, 8'd0,   8'd0,  8'd0,  8'd0,  8'd0 },
    {1'b0, 8'd255, 8'd64, 8'd64, 8'd64, 8'd63},
    {1'b0, 8'd3,   8'd1,  8'd1,  8'd1,  8'd0 },
    {1'b0, 8'd4,   8'd1,  8'd1,  8'd1,  8'd1 },
    {1'b1, 8'd100, 8'd50, 8'd0,  8'd50, 8'd0 },
    {1'b1, 8'd101, 8'd51, 8'd0,  8'd50, 8'd0 },
    {1'b1, 8'd255, 8'd64, 8'd64, 8'd64, 8'd63},
    {1'b1, 8'd1,   8'd1,  8'd0,  8'd0,  8'd0 },
    {1'b1, 8'd0,   8'd0,  8'd0,  8'd0,  8'd0 },
    {1'b1, 8'd200, 8'd64, 8'd36, 8'd64, 8'd36},
    {1'b1, 8'd129, 8'd64, 8'd1,  8'd64, 8'd0 }
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] duty_in = '0;
  logic       duty_we = 1'b0;
  logic       mode_sel = 1'b0;
  logic       pwm_en = 1'b0;
  logic       pwm_out;

  int total = 0;
  int bad = 0;
  logic [31:0] got_q;
  logic        shape_ok;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpwm_top dut (
    .clk(clk), .rst(rst), .duty_in(duty_in), .duty_we(duty_we),
    .mode_sel(mode_sel), .pwm_en(pwm_en), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // 256 falling-edge samples of one period; optional write at sample wpos
  task automatic capture(input logic seg_dual, input int wpos,
                         input logic [7:0] wdata, input logic wmode);
    logic [7:0] q [4];
    bit seen_low;
    int seg_len;
    q = '{default: '0};
    shape_ok = 1'b1;
    seen_low = 1'b0;
    seg_len = seg_dual ? 128 : 64;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (i % seg_len == 0) seen_low = 1'b0;
      if (pwm_out) begin
        q[i/64]++;
        if (seen_low) shape_ok = 1'b0;
      end else begin
        seen_low = 1'b1;
      end
      if (i == wpos) begin
        duty_in = wdata; duty_we = 1'b1; mode_sel = wmode;
      end
      if (i == wpos + 1) duty_we = 1'b0;
    end
    got_q = {q[0], q[1], q[2], q[3]};
  endtask

  task automatic setup(input logic m, input logic [7:0] d);
    @(negedge clk);
    pwm_en = 1'b0; duty_in = d; duty_we = 1'b1; mode_sel = m;
    @(negedge clk);
    duty_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pwm_en = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R1 out low in reset", 32'(pwm_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R1 out low after reset", 32'(pwm_out), 0);

    // R3 R4 R5 R9 R2: table walk
    for (int v = 0; v < NV; v++) begin
      setup(TBL[v][40], TBL[v][39:32]);
      capture(TBL[v][40], -1, 8'd0, 1'b0);
      chk(got_q == TBL[v][31:0], TBL[v][40] ? "R4 R2 dual split counts" : "R3 R2 quad split counts",
          got_q, TBL[v][31:0]);
      chk(shape_ok, "R5 high-first contiguity", 32'(shape_ok), 1);
    end

    // R6: mid-period write waits for boundary
    setup(1'b0, 8'd100);
    capture(1'b0, 10, 8'd103, 1'b0);
    chk(got_q == {8'd25, 8'd25, 8'd25, 8'd25}, "R6 old duty kept", got_q, {8'd25, 8'd25, 8'd25, 8'd25});
    // R6: write on the last clock of a period
    capture(1'b0, 254, 8'd1, 1'b0);
    chk(got_q == {8'd26, 8'd26, 8'd26, 8'd25}, "R6 new duty next period", got_q, {8'd26, 8'd26, 8'd26, 8'd25});
    // R7: mode change mid-period
    capture(1'b0, 100, 8'd101, 1'b1);
    chk(got_q == {8'd1, 8'd0, 8'd0, 8'd0}, "R6 last-clock write applied", got_q, {8'd1, 8'd0, 8'd0, 8'd0});
    capture(1'b1, -1, 8'd0, 1'b1);
    chk(got_q == {8'd51, 8'd0, 8'd50, 8'd0}, "R7 mode at boundary", got_q, {8'd51, 8'd0, 8'd50, 8'd0});

    // R8: disable mid-period, hold low, restart at sub-cycle 0
    setup(1'b0, 8'd255);
    repeat (100) @(negedge clk);
    pwm_en = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R8 low one edge after disable", 32'(pwm_out), 0);
    begin
      int highs = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (pwm_out) highs++;
      end
      chk(highs == 0, "R8 stays low while disabled", 32'(highs), 0);
    end
    pwm_en = 1'b1;
    capture(1'b0, -1, 8'd0, 1'b0);
    chk(got_q == {8'd64, 8'd64, 8'd64, 8'd63}, "R8 restart at sub-cycle 0", got_q, {8'd64, 8'd64, 8'd64, 8'd63});

    // R2: position 0 shows after the enabling edge
    setup(1'b0, 8'd4);
    @(negedge clk);
    chk(pwm_out == 1'b1, "R2 first position registered", 32'(pwm_out), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule